// File: doc/BRIEF.md
# Strobe-Handshake Peripheral Register Slave

This block is a memory-mapped slave for an asynchronous bus that uses an address strobe, two byte-lane data strobes and a transfer acknowledge. It occupies a two-word window at a parameterised word address. The even word holds a 16-bit control/status word, and the odd word holds a data buffer whose low byte carries the data. All bus inputs are sampled on the block clock. The acknowledge and the read data come from registers, so no combinational path runs from a bus input to a bus output.

The device-side core runs jobs. It sees the enable, function and unit fields, a one-clock start pulse and the buffer byte. In return it reports job completion, sticky error flags and new buffer bytes. A level interrupt request is raised while a finished job is pending, interrupts are enabled and the device is enabled.

Top module: `hsk_periph_slave`

## Requirements
- R1: A bus access is served only when the word address falls inside the window: the control word at word BASE_WADDR (address bit 0 clear) and the buffer at BASE_WADDR+1. Any other address gets no acknowledge, and its state is left untouched.
- R2: An access qualifies when the address strobe is low, at least one data strobe is low, the address hits, and the acknowledge is not already held. The acknowledge (active low) is asserted at the first clock edge that sees a qualifying access. It holds while the address strobe stays low and is released at the first edge that sees the address strobe high. With no data strobe low there is no acknowledge.
- R3: Only a write (read/write line low) changes registers. The upper data strobe covers bits 15..8 and the lower data strobe covers bits 7..0. A lane whose strobe is high keeps its old contents, and each bus cycle performs its access once.
- R4: On a read the slave drives the word while the acknowledge is asserted. A lane whose strobe is high reads as zero.
- R5: Control-word layout: errors [15:12], busy [11], unit [10:8], done [7], irq-enable [6], reserved [5:3], function [2:1], enable [0]. Reserved bits read zero. Errors, busy and done ignore bus writes. Reset clears every field.
- R6: A write that covers the lower lane of the control word starts a job when it sets enable with a non-zero function. The start sets busy, clears done and the error flags, and gives one `job_start` pulse in the cycle after the write edge. A start takes priority over core events in the same cycle.
- R7: A `core_done` pulse clears busy and sets done. Error bits set by `core_err` are OR-ed into the error flags and stay set until the next start.
- R8: Buffer bits 15..8 read zero. A lower-lane bus write or a `core_load` pulse replaces the low byte, and the bus write wins when both occur in the same cycle. An upper-lane-only write is ignored.
- R9: Any read of the buffer word clears done, except in a cycle where `core_done` also arrives; then done ends up set.
- R10: `irq` is a level equal to done AND irq-enable AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 23 | Word address |
| bus_data | inout | 16 | Bidirectional data bus |
| bus_as_n | input | 1 | Address strobe, low = address valid |
| bus_rw | input | 1 | High = read, low = write |
| bus_uds_n | input | 1 | Upper byte strobe, active low |
| bus_lds_n | input | 1 | Lower byte strobe, active low |
| bus_ack_n | output | 1 | Transfer acknowledge, active low |
| irq | output | 1 | Level interrupt request |
| core_done | input | 1 | Job-complete pulse from the device core |
| core_err | input | 4 | Error flags to set |
| core_load | input | 1 | Load pulse for the buffer byte |
| core_byte | input | 8 | Byte from the device core |
| job_start | output | 1 | One-clock job start pulse |
| job_enable | output | 1 | Enable field |
| job_func | output | 2 | Function field |
| job_unit | output | 3 | Unit field |
| buf_byte | output | 8 | Buffer byte toward the core |

## Verification
Stimulus changes on the falling edge. Every register update then lands on the next rising edge and shows at the ports at the falling edge after that, one clock later. Each result is due at a fixed point:
- The acknowledge and read data appear one clock after the strobes are driven.
- The acknowledge releases one clock after the address strobe rises.
- `job_start`, the field outputs, the buffer byte and `irq` follow one clock after the write or core pulse that causes them.

A behavioural model in the bench advances on each rising edge, and every falling edge compares all outputs against it. Read data and the acknowledge are sampled at exactly those offsets, and misses are watched for several clocks.

// File: rtl/hsk_regs_pkg.sv
package hsk_regs_pkg;
  localparam int WORD_W = 16;
  localparam int ERR_W  = 4;

  typedef struct packed {
    logic [ERR_W-1:0] err;
    logic             busy;
    logic [2:0]       unit;
    logic             done;
    logic             ie;
    logic [2:0]       rsvd;
    logic [1:0]       func;
    logic             en;
  } ctl_word_t;

  // readback of the control word with reserved bits forced to zero
  function automatic logic [WORD_W-1:0] ctl_pack(input ctl_word_t c);
    ctl_word_t t;
    t      = c;
    t.rsvd = 3'b000;
    return t;
  endfunction

  // keep only the byte lanes whose strobes are active
  function automatic logic [WORD_W-1:0] lane_mask(input logic [WORD_W-1:0] w,
                                                  input logic up, input logic lo);
    return {up ? w[15:8] : 8'h00, lo ? w[7:0] : 8'h00};
  endfunction

  // two-word window: every bit except the lowest must match
  function automatic logic win_hit(input logic [22:0] a, input logic [22:0] base);
    return a[22:1] == base[22:1];
  endfunction

  // a control write starts a job when enable is set with a non-zero function
  function automatic logic is_start(input logic [WORD_W-1:0] w);
    return w[0] && (w[2:1] != 2'b00);
  endfunction
endpackage

// File: rtl/hsk_bus_port.sv
module hsk_bus_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_n,
  input  logic          uds_n,
  input  logic          lds_n,
  input  logic          rw,
  input  logic          hit,
  input  logic [DW-1:0] rd_word,
  output logic          acc_ev,
  output logic          wr_ev,
  output logic          rd_ev,
  output logic          ack_n,
  output logic          drive_en,
  output logic [DW-1:0] drive_word
);
  logic ack_q;

  assign acc_ev = !as_n && hit && (!uds_n || !lds_n) && !ack_q;
  assign wr_ev  = acc_ev && !rw;
  assign rd_ev  = acc_ev && rw;
  assign ack_n  = !ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      drive_en   <= 1'b0;
      drive_word <= '0;
    end else if (as_n) begin
      ack_q    <= 1'b0;
      drive_en <= 1'b0;
    end else if (acc_ev) begin
      ack_q    <= 1'b1;
      drive_en <= rw;
      if (rw) drive_word <= rd_word;
    end
  end

  assert_ack_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(!as_n && hit && (!uds_n || !lds_n)));
  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n) |-> ack_n);
  assert_drive_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !ack_n);
endmodule

// File: rtl/hsk_ctl_bank.sv
module hsk_ctl_bank
  import hsk_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_up,
  input  logic             wr_lo,
  input  logic [10:0]      wdata,
  input  logic             done_clr,
  input  logic             core_done,
  input  logic [ERR_W-1:0] core_err,
  output ctl_word_t        ctl,
  output logic             start_ev,
  output logic             start_q
);
  assign start_ev = wr_lo && is_start({5'b0, wdata});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_ev;
      ctl.err <= ctl.err | core_err;
      if (core_done) begin
        ctl.busy <= 1'b0;
        ctl.done <= 1'b1;
      end else if (done_clr) begin
        ctl.done <= 1'b0;
      end
      if (wr_up) ctl.unit <= wdata[10:8];
      if (wr_lo) begin
        ctl.ie   <= wdata[6];
        ctl.func <= wdata[2:1];
        ctl.en   <= wdata[0];
      end
      if (start_ev) begin
        ctl.busy <= 1'b1;
        ctl.done <= 1'b0;
        ctl.err  <= '0;
      end
    end
  end

  assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (ctl.busy && !ctl.done && ctl.err == '0 && start_q));
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && !start_ev) |=> (ctl.done && !ctl.busy));
  assert_dbr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !core_done && !start_ev) |=> !ctl.done);
  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rsvd == 3'b000);
endmodule

// File: rtl/hsk_buf_reg.sv
module hsk_buf_reg #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [BW-1:0] bus_byte,
  input  logic          core_load,
  input  logic [BW-1:0] core_byte,
  output logic [BW-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)         byte_q <= '0;
    else if (bus_wr)    byte_q <= bus_byte;
    else if (core_load) byte_q <= core_byte;
  end

  assert_bus_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> byte_q == $past(bus_byte));
endmodule

// File: rtl/hsk_periph_slave.sv
module hsk_periph_slave
  import hsk_regs_pkg::*;
#(
  parameter int          AW         = 23,
  parameter logic [22:0] BASE_WADDR = 23'h40_0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  inout  wire  [15:0]      bus_data,
  input  logic             bus_as_n,
  input  logic             bus_rw,
  input  logic             bus_uds_n,
  input  logic             bus_lds_n,
  output logic             bus_ack_n,
  output logic             irq,
  input  logic             core_done,
  input  logic [ERR_W-1:0] core_err,
  input  logic             core_load,
  input  logic [7:0]       core_byte,
  output logic             job_start,
  output logic             job_enable,
  output logic [1:0]       job_func,
  output logic [2:0]       job_unit,
  output logic [7:0]       buf_byte
);
  logic            hit, sel_buf;
  logic            acc_ev, wr_ev, rd_ev, drive_en, start_ev;
  logic [WORD_W-1:0] rd_word, drive_word, wd;
  ctl_word_t       ctl;
  logic            unused_wbits;

  assign wd           = bus_data;
  assign unused_wbits = ^{wd[15:11]};
  assign hit          = win_hit(bus_addr, BASE_WADDR);
  assign sel_buf      = bus_addr[0];
  assign rd_word      = lane_mask(sel_buf ? {8'h00, buf_byte} : ctl_pack(ctl),
                                  !bus_uds_n, !bus_lds_n);

  hsk_bus_port #(.DW(WORD_W)) u_port (
    .clk(clk), .rst_n(rst_n), .as_n(bus_as_n), .uds_n(bus_uds_n),
    .lds_n(bus_lds_n), .rw(bus_rw), .hit(hit), .rd_word(rd_word),
    .acc_ev(acc_ev), .wr_ev(wr_ev), .rd_ev(rd_ev), .ack_n(bus_ack_n),
    .drive_en(drive_en), .drive_word(drive_word)
  );

  hsk_ctl_bank u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_up(wr_ev && !sel_buf && !bus_uds_n),
    .wr_lo(wr_ev && !sel_buf && !bus_lds_n),
    .wdata(wd[10:0]),
    .done_clr(rd_ev && sel_buf),
    .core_done(core_done), .core_err(core_err),
    .ctl(ctl), .start_ev(start_ev), .start_q(job_start)
  );

  hsk_buf_reg #(.BW(8)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(wr_ev && sel_buf && !bus_lds_n), .bus_byte(wd[7:0]),
    .core_load(core_load), .core_byte(core_byte), .byte_q(buf_byte)
  );

  assign bus_data   = drive_en ? drive_word : 16'hzzzz;
  assign irq        = ctl.done && ctl.ie && ctl.en;
  assign job_enable = ctl.en;
  assign job_func   = ctl.func;
  assign job_unit   = ctl.unit;

  assert_miss_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && bus_ack_n) |=> bus_ack_n);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(core_done || wr_ev));
  assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> !acc_ev);
  assert_start_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |-> (wr_ev && !bus_lds_n));
endmodule

// File: tb/tb_hsk_periph_slave.sv
`timescale 1ns/1ps
module tb_hsk_periph_slave;
  localparam logic [22:0] BASE = 23'h40_0010;
  localparam logic [22:0] A_CTL = BASE;
  localparam logic [22:0] A_BUF = BASE | 23'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] bus_addr = '0;
  wire  [15:0] bus_data;
  logic        bus_as_n = 1'b1, bus_rw = 1'b1, bus_uds_n = 1'b1, bus_lds_n = 1'b1;
  logic        bus_ack_n, irq;
  logic        core_done = 1'b0, core_load = 1'b0;
  logic [3:0]  core_err = '0;
  logic [7:0]  core_byte = '0;
  logic        job_start, job_enable;
  logic [1:0]  job_func;
  logic [2:0]  job_unit;
  logic [7:0]  buf_byte;
  logic        tb_oe = 1'b0;
  logic [15:0] tb_wd = '0;
  logic [15:0] got;
  int          nchk = 0, nfail = 0;
  bit          done_flag = 0;

  assign bus_data = tb_oe ? tb_wd : 16'hzzzz;
  always #2 clk = ~clk;

  hsk_periph_slave #(.BASE_WADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_as_n(bus_as_n), .bus_rw(bus_rw), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_ack_n(bus_ack_n), .irq(irq), .core_done(core_done), .core_err(core_err),
    .core_load(core_load), .core_byte(core_byte), .job_start(job_start),
    .job_enable(job_enable), .job_func(job_func), .job_unit(job_unit), .buf_byte(buf_byte)
  );

  // behavioural reference state
  bit m_ack, m_busy, m_done, m_ie, m_en, m_start;
  bit [3:0] m_err;
  bit [2:0] m_unit;
  bit [1:0] m_func;
  bit [7:0] m_byte;
  bit q, wu, wl, isbuf, st, rclr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack = 0; m_busy = 0; m_done = 0; m_ie = 0; m_en = 0; m_start = 0;
      m_err = 0; m_unit = 0; m_func = 0; m_byte = 0;
    end else begin
      q     = !bus_as_n && (bus_addr[22:1] == BASE[22:1]) && (!bus_uds_n || !bus_lds_n) && !m_ack;
      wu    = q && !bus_rw && !bus_uds_n;
      wl    = q && !bus_rw && !bus_lds_n;
      isbuf = bus_addr[0];
      st    = wl && !isbuf && tb_wd[0] && (tb_wd[2:1] != 0);
      rclr  = q && bus_rw && isbuf;
      if (bus_as_n) m_ack = 0; else if (q) m_ack = 1;
      m_err = m_err | core_err;
      if (core_done) begin m_busy = 0; m_done = 1; end
      else if (rclr) m_done = 0;
      if (wu && !isbuf) m_unit = tb_wd[10:8];
      if (wl && !isbuf) begin m_ie = tb_wd[6]; m_func = tb_wd[2:1]; m_en = tb_wd[0]; end
      if (st) begin m_busy = 1; m_done = 0; m_err = 0; end
      m_start = st;
      if (wl && isbuf) m_byte = tb_wd[7:0];
      else if (core_load) m_byte = core_byte;
    end
  end

  // per-clock comparison of every output against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      nchk++;
      if (bus_ack_n !== !m_ack || irq !== (m_done && m_ie && m_en) || job_start !== m_start ||
          job_enable !== m_en || job_func !== m_func || job_unit !== m_unit || buf_byte !== m_byte) begin
        nfail++;
        $display("FAIL R2 R6 R8 R10 per-clock: ack_n %b/%b irq %b/%b start %b/%b en %b/%b func %0d/%0d unit %0d/%0d byte %h/%h",
                 bus_ack_n, !m_ack, irq, (m_done && m_ie && m_en), job_start, m_start,
                 job_enable, m_en, job_func, m_func, job_unit, m_unit, buf_byte, m_byte);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [22:0] a, input logic rd, input logic u, input logic l,
                           input logic [15:0] wd, output logic [15:0] rdv);
    bit h;
    h = (a[22:1] == BASE[22:1]);
    @(negedge clk);
    bus_addr = a; bus_rw = rd; bus_uds_n = !u; bus_lds_n = !l;
    tb_wd = wd; tb_oe = !rd; bus_as_n = 0;
    @(negedge clk);
    rdv = bus_data;
    if (h) chk("R2 ack one clock after strobe", {15'd0, bus_ack_n}, 16'd0);
    else begin
      repeat (3) @(negedge clk);
      chk("R1 no ack outside window", {15'd0, bus_ack_n}, 16'd1);
    end
    @(negedge clk);
    if (h) chk("R2 ack held while strobe low", {15'd0, bus_ack_n}, 16'd0);
    bus_as_n = 1; bus_uds_n = 1; bus_lds_n = 1; tb_oe = 0; bus_rw = 1;
    @(negedge clk);
    chk("R2 ack released", {15'd0, bus_ack_n}, 16'd1);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  task automatic pulse_err(input logic [3:0] e);
    @(negedge clk); core_err = e;
    @(negedge clk); core_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset ack idle", {15'd0, bus_ack_n}, 16'd1);
    chk("R10 reset irq low", {15'd0, irq}, 16'd0);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R5 reset control word", got, 16'h0000);
    // R6: full-word write starts a job, read-only fields ignore bus data
    bus_cycle(A_CTL, 0, 1, 1, 16'hFFFF, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R5 R6 control after full write", got, 16'h0F47);
    // R7: errors sticky, completion sets done
    pulse_err(4'b0101);
    pulse_done();
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R7 done and errors", got, 16'h57C7);
    chk("R10 irq on done", {15'd0, irq}, 16'd1);
    pulse_err(4'b0010);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R7 errors accumulate", got, 16'h77C7);
    // R3: lane writes
    bus_cycle(A_CTL, 0, 1, 0, 16'h0000, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R3 upper lane only", got, 16'h70C7);
    bus_cycle(A_CTL, 0, 0, 1, 16'hFF3E, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R3 R5 lower lane only", got, 16'h7086);
    chk("R10 irq off when ie clear", {15'd0, irq}, 16'd0);
    bus_cycle(A_CTL, 0, 0, 1, 16'h0041, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R6 no start with zero function", got, 16'h70C1);
    chk("R10 irq back on", {15'd0, irq}, 16'd1);
    // R4: lane-masked reads
    bus_cycle(A_CTL, 1, 0, 1, 0, got);
    chk("R4 lower lane read", got, 16'h00C1);
    bus_cycle(A_CTL, 1, 1, 0, 0, got);
    chk("R4 upper lane read", got, 16'h7000);
    // R8/R9: buffer load and read clears done
    @(negedge clk); core_load = 1; core_byte = 8'hA5;
    @(negedge clk); core_load = 0;
    bus_cycle(A_BUF, 1, 1, 1, 0, got);
    chk("R8 buffer read", got, 16'h00A5);
    chk("R9 irq clears after buffer read", {15'd0, irq}, 16'd0);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R9 done cleared", got, 16'h7041);
    fork
      bus_cycle(A_BUF, 0, 1, 1, 16'h1234, got);
      begin @(negedge clk); core_load = 1; core_byte = 8'hC3; @(negedge clk); core_load = 0; end
    join
    bus_cycle(A_BUF, 1, 1, 1, 0, got);
    chk("R8 bus write wins over load", got, 16'h0034);
    bus_cycle(A_BUF, 0, 1, 0, 16'hABCD, got);
    bus_cycle(A_BUF, 1, 1, 1, 0, got);
    chk("R8 upper-lane buffer write ignored", got, 16'h0034);
    // R1: misses
    bus_cycle(BASE + 23'd2, 1, 1, 1, 0, got);
    bus_cycle(BASE - 23'd1, 0, 1, 1, 16'hFFFF, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R1 state untouched by misses", got, 16'h7041);
    // R6 restart clears errors; R9 done wins over simultaneous buffer read
    bus_cycle(A_CTL, 0, 0, 1, 16'h0003, got);
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R6 restart clears errors", got, 16'h0803);
    fork
      bus_cycle(A_BUF, 1, 1, 1, 0, got);
      begin @(negedge clk); core_done = 1; @(negedge clk); core_done = 0; end
    join
    bus_cycle(A_CTL, 1, 1, 1, 0, got);
    chk("R9 done wins over read clear", got, 16'h0083);
    // R2: address strobe without data strobes
    @(negedge clk); bus_addr = A_CTL; bus_as_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 no ack without data strobe", {15'd0, bus_ack_n}, 16'd1);
    bus_as_n = 1;
    repeat (2) @(negedge clk);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule